// File: doc/BRIEF.md
# Message-Signalled Interrupt Controller

This block gathers level-sensitive interrupt lines from expansion slots and on-chip sources and turns them into memory-write messages. It keeps a register with the current level of every line. Each line is gated by an enable mask. A class vector then sends each line to one of two programmable destination registers.

When an enabled line goes from low to high, the block queues exactly one message for it. The message carries an address and a data word, both taken from the chosen destination register. The address is the register value with its five low bits cleared, and the data is those five low bits. The message leaves on a valid/ready port.

When several lines rise together, their messages leave one at a time, lowest index first. A message stays on the port, unchanged, until the receiver accepts it. Software sees the level register, a pending register that clears when read or written, and two status views: the enabled lines of class 0 and the enabled lines of class 1. Line 6 is reserved for the external bus interrupt and line 7 for the non-fatal bus error.

Top module: `msi_intr_ctrl`

## Requirements
- R1: The level register (word offset 4) holds the input levels as of the previous clock edge: a bit is 1 while its input is high and 0 once it falls. Writes to offset 4 have no effect.
- R2: A message is queued only when an enabled input rises, meaning its level bit was 0. An input held high produces exactly one message until it falls and rises again.
- R3: A rising input whose mask bit (offset 2, bit i for input i) is 0 updates the level register but sends no message and leaves the pending register untouched.
- R4: The destination is taken from register 1 (offset 1) when the source's class bit (offset 3) is 1, and from register 0 (offset 0) otherwise.
- R5: The message address equals the destination value with bits [4:0] forced to 0. The message data equals destination bits [4:0], zero-extended.
- R6: After reset, both destination registers read 0xFFFB0003, mask, class and pending read 0, and no message is valid.
- R7: The view at offset 6 reads level AND mask AND NOT class. The view at offset 7 reads level AND mask AND class.
- R8: A bit of the pending register (offset 5) is set when an enabled rising edge is accepted. Any read of offset 5 returns its value and then clears it, and any write to offset 5 clears it. Edges arriving in the same cycle as the clear are kept.
- R9: Messages for inputs that rise together are sent one per accepted handshake, in ascending input order.
- R10: While msg_valid_o is high and msg_ready_i is low, msg_valid_o stays high and the address and data stay unchanged. A message counts as delivered on a clock edge where both are high. Read data appears on reg_rdata_o one cycle after a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | N_SRC | Level-sensitive interrupt inputs, synchronous to clk |
| reg_en_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 3 | Word offset of the register |
| reg_wdata_i | input | AW | Write data |
| reg_rdata_o | output | AW | Read data, registered |
| msg_valid_o | output | 1 | A message is offered |
| msg_ready_i | input | 1 | The receiver accepts the message |
| msg_addr_o | output | AW | Message address |
| msg_data_o | output | DW | Message data |

## Verification
The properties take it that irq_i and the register strobes are synchronous to clk and settle between edges. They also take it that msg_ready_i may drop at any time, since the payload is latched and does not depend on it. Ordering and destination checks further assume that the class and destination registers are left alone while messages are outstanding. The stimulus respects these assumptions. Every input change is made at a falling edge, or just after a rising edge in the case of ready. Ready follows a stall pattern during the burst test, and destination and class are rewritten only after the previous messages have drained.

// File: rtl/msi_pkg.sv
package msi_pkg;
  // Register word offsets; the port decodes these three bits.
  localparam logic [2:0] OFS_DEST0 = 3'd0;
  localparam logic [2:0] OFS_DEST1 = 3'd1;
  localparam logic [2:0] OFS_MASK  = 3'd2;
  localparam logic [2:0] OFS_CLASS = 3'd3;
  localparam logic [2:0] OFS_LEVEL = 3'd4;
  localparam logic [2:0] OFS_PEND  = 3'd5;
  localparam logic [2:0] OFS_VIEW0 = 3'd6;
  localparam logic [2:0] OFS_VIEW1 = 3'd7;

  // Fixed on-chip source positions.
  localparam int SRC_EXT_BUS = 6;
  localparam int SRC_BUS_ERR = 7;

  // Low address bits that carry the message data.
  localparam int DATA_BITS = 5;
endpackage

// File: rtl/msi_level_tracker.sv
module msi_level_tracker #(
  parameter int N_SRC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_i,
  output logic [N_SRC-1:0] level_o,
  output logic [N_SRC-1:0] rise_o
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic lvl_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= irq_i[g];
    end
    assign level_o[g] = lvl_q;
    // New assertion: input high while the stored level is still low.
    assign rise_o[g]  = irq_i[g] & ~lvl_q;
  end
endmodule

// File: rtl/msi_regfile.sv
module msi_regfile
  import msi_pkg::*;
#(
  parameter int          N_SRC    = 16,
  parameter int          AW       = 32,
  parameter logic [AW-1:0] DEST_RST = 32'hFFFB_0003
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_en_i,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [AW-1:0]    reg_wdata_i,
  output logic [AW-1:0]    reg_rdata_o,
  input  logic [N_SRC-1:0] level_i,
  input  logic [N_SRC-1:0] event_i,
  output logic [AW-1:0]    dest0_o,
  output logic [AW-1:0]    dest1_o,
  output logic [N_SRC-1:0] mask_o,
  output logic [N_SRC-1:0] cls_o
);
  logic [AW-1:0]    dest0_q, dest1_q, rdata_q, rd_mux;
  logic [N_SRC-1:0] mask_q, cls_q, pend_q, view0, view1;
  logic             wr, rd, pend_touch;

  assign wr         = reg_en_i & reg_we_i;
  assign rd         = reg_en_i & ~reg_we_i;
  assign pend_touch = reg_en_i & (reg_addr_i == OFS_PEND);
  assign view0      = level_i & mask_q & ~cls_q;
  assign view1      = level_i & mask_q & cls_q;

  always_comb begin
    unique case (reg_addr_i)
      OFS_DEST0: rd_mux = dest0_q;
      OFS_DEST1: rd_mux = dest1_q;
      OFS_MASK:  rd_mux = AW'(mask_q);
      OFS_CLASS: rd_mux = AW'(cls_q);
      OFS_LEVEL: rd_mux = AW'(level_i);
      OFS_PEND:  rd_mux = AW'(pend_q);
      OFS_VIEW0: rd_mux = AW'(view0);
      default:   rd_mux = AW'(view1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest0_q <= DEST_RST;
      dest1_q <= DEST_RST;
      mask_q  <= '0;
      cls_q   <= '0;
      pend_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (wr) begin
        case (reg_addr_i)
          OFS_DEST0: dest0_q <= reg_wdata_i;
          OFS_DEST1: dest1_q <= reg_wdata_i;
          OFS_MASK:  mask_q  <= reg_wdata_i[N_SRC-1:0];
          OFS_CLASS: cls_q   <= reg_wdata_i[N_SRC-1:0];
          default:   ;
        endcase
      end
      // Access clears; edges of the same cycle still land.
      pend_q <= (pend_touch ? '0 : pend_q) | event_i;
      if (rd) rdata_q <= rd_mux;
    end
  end

  assign reg_rdata_o = rdata_q;
  assign dest0_o     = dest0_q;
  assign dest1_o     = dest1_q;
  assign mask_o      = mask_q;
  assign cls_o       = cls_q;
endmodule

// File: rtl/msi_dispatch.sv
module msi_dispatch
  import msi_pkg::*;
#(
  parameter int N_SRC = 16,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] event_i,
  input  logic [N_SRC-1:0] cls_i,
  input  logic [AW-1:0]    dest0_i,
  input  logic [AW-1:0]    dest1_i,
  output logic             valid_o,
  input  logic             ready_i,
  output logic [AW-1:0]    addr_o,
  output logic [DW-1:0]    data_o,
  output logic [N_SRC-1:0] queued_o,
  output logic [N_SRC-1:0] pop_o
);
  logic [N_SRC-1:0] queued_q, pick, pop;
  logic [AW-1:0]    sel, addr_q;
  logic [DW-1:0]    data_q;
  logic             valid_q, load;

  // Isolate the lowest queued source.
  assign pick = queued_q & (~queued_q + 1'b1);
  assign load = (|queued_q) & (~valid_q | ready_i);
  assign pop  = load ? pick : '0;
  assign sel  = (|(pick & cls_i)) ? dest1_i : dest0_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      queued_q <= '0;
      valid_q  <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      queued_q <= (queued_q & ~pop) | event_i;
      if (load) begin
        valid_q <= 1'b1;
        addr_q  <= {sel[AW-1:DATA_BITS], {DATA_BITS{1'b0}}};
        data_q  <= DW'(sel[DATA_BITS-1:0]);
      end else if (ready_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign valid_o  = valid_q;
  assign addr_o   = addr_q;
  assign data_o   = data_q;
  assign queued_o = queued_q;
  assign pop_o    = pop;
endmodule

// File: rtl/msi_intr_ctrl.sv
module msi_intr_ctrl
  import msi_pkg::*;
#(
  parameter int N_SRC = 16,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_i,
  input  logic             reg_en_i,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [AW-1:0]    reg_wdata_i,
  output logic [AW-1:0]    reg_rdata_o,
  output logic             msg_valid_o,
  input  logic             msg_ready_i,
  output logic [AW-1:0]    msg_addr_o,
  output logic [DW-1:0]    msg_data_o
);
  logic [N_SRC-1:0] level_w, rise_w, event_w, mask_w, cls_w, queued_w, pop_w;
  logic [AW-1:0]    dest0_w, dest1_w;

  assign event_w = rise_w & mask_w;

  msi_level_tracker #(.N_SRC(N_SRC)) u_level (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i),
    .level_o(level_w), .rise_o(rise_w)
  );

  msi_regfile #(.N_SRC(N_SRC), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_en_i(reg_en_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .level_i(level_w), .event_i(event_w),
    .dest0_o(dest0_w), .dest1_o(dest1_w), .mask_o(mask_w), .cls_o(cls_w)
  );

  msi_dispatch #(.N_SRC(N_SRC), .AW(AW), .DW(DW)) u_disp (
    .clk(clk), .rst_n(rst_n), .event_i(event_w), .cls_i(cls_w),
    .dest0_i(dest0_w), .dest1_i(dest1_w),
    .valid_o(msg_valid_o), .ready_i(msg_ready_i),
    .addr_o(msg_addr_o), .data_o(msg_data_o),
    .queued_o(queued_w), .pop_o(pop_w)
  );
endmodule

// File: rtl/msi_intr_ctrl_chk.sv
module msi_intr_ctrl_chk #(
  parameter int N_SRC = 16,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid_o,
  input logic             msg_ready_i,
  input logic [AW-1:0]    msg_addr_o,
  input logic [DW-1:0]    msg_data_o,
  input logic [N_SRC-1:0] queued_w,
  input logic [N_SRC-1:0] pop_w
);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_addr_o) && $stable(msg_data_o));
  // R5
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o |-> msg_addr_o[4:0] == 5'd0);
  // R5
  data_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o |-> msg_data_o[DW-1:5] == '0);
  // R9
  single_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop_w));
  // R2
  rise_from_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid_o) |-> $past(|queued_w));
endmodule

bind msi_intr_ctrl msi_intr_ctrl_chk #(.N_SRC(N_SRC), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid_o(msg_valid_o), .msg_ready_i(msg_ready_i),
  .msg_addr_o(msg_addr_o), .msg_data_o(msg_data_o),
  .queued_w(queued_w), .pop_w(pop_w)
);

// File: tb/msi_intr_ctrl_bench.sv
module msi_intr_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] irq_i = '0;
  logic          reg_en_i = 1'b0, reg_we_i = 1'b0;
  logic [2:0]    reg_addr_i = '0;
  logic [AW-1:0] reg_wdata_i = '0, reg_rdata_o, msg_addr_o;
  logic [DW-1:0] msg_data_o;
  logic          msg_valid_o, msg_ready_i = 1'b1;

  int n_checks = 0, n_fail = 0, log_n = 0;
  logic [AW-1:0] log_addr [0:63];
  logic [DW-1:0] log_data [0:63];
  bit stall_mode = 1'b0, finished = 1'b0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_intr_ctrl #(.N_SRC(NS), .AW(AW), .DW(DW)) u_msi_intr_ctrl (.*);

  // Ready changes just after the rising edge.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 msg_ready_i = stall_mode ? (cyc % 3 == 0) : 1'b1;
  end

  // Record handshakes at the falling edge; the transfer completes at the next rise.
  always @(negedge clk) begin
    if (rst_n && msg_valid_o && msg_ready_i && log_n < 64) begin
      log_addr[log_n] = msg_addr_o;
      log_data[log_n] = msg_data_o;
      log_n = log_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [AW-1:0] d);
    @(negedge clk);
    reg_en_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_en_i = 1'b0; reg_we_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [AW-1:0] d);
    @(negedge clk);
    reg_en_i = 1'b1; reg_we_i = 1'b0; reg_addr_i = a;
    @(negedge clk);
    reg_en_i = 1'b0;
    d = reg_rdata_o;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [AW-1:0] v;
    logic [AW-1:0] d0, d1, dsel;
    int base;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R6 reset state
    check(msg_valid_o == 1'b0, "R6 valid", AW'(msg_valid_o), 0);
    reg_rd(3'd0, v); check(v == 32'hFFFB0003, "R6 dest0", v, 32'hFFFB0003);
    reg_rd(3'd1, v); check(v == 32'hFFFB0003, "R6 dest1", v, 32'hFFFB0003);
    reg_rd(3'd2, v); check(v == 0, "R6 mask", v, 0);
    reg_rd(3'd3, v); check(v == 0, "R6 class", v, 0);
    reg_rd(3'd5, v); check(v == 0, "R6 pend", v, 0);

    // R4 R5 R8: one source at a time, classes alternating
    reg_wr(3'd2, 32'hFF);
    reg_wr(3'd3, 32'hAA);
    for (int s = 0; s < NS; s++) begin
      d0 = 32'h8000_0000 + s * 32'h0001_0100 + s;
      d1 = 32'h4000_0000 + s * 32'h0000_2340 + (s + 9);
      reg_wr(3'd0, d0);
      reg_wr(3'd1, d1);
      base = log_n;
      @(negedge clk); irq_i[s] = 1'b1;
      idle(6);
      dsel = s[0] ? d1 : d0;
      check(log_n == base + 1, "R2 single message", AW'(log_n - base), 1);
      check(log_addr[base] == (dsel & ~32'h1F), "R4/R5 address", log_addr[base], dsel & ~32'h1F);
      check(log_data[base] == (dsel & 32'h1F), "R5 data", log_data[base], dsel & 32'h1F);
      reg_rd(3'd5, v); check(v == (32'h1 << s), "R8 pending set", v, 32'h1 << s);
      reg_rd(3'd5, v); check(v == 0, "R8 cleared by read", v, 0);
      @(negedge clk); irq_i[s] = 1'b0;
      idle(2);
      reg_rd(3'd4, v); check(v == 0, "R1 level falls", v, 0);
    end

    // R3 masked sources
    for (int s = 0; s < NS; s++) begin
      reg_wr(3'd2, ~(32'h1 << s) & 32'hFF);
      base = log_n;
      @(negedge clk); irq_i[s] = 1'b1;
      idle(6);
      check(log_n == base, "R3 no message", AW'(log_n - base), 0);
      reg_rd(3'd4, v); check(v == (32'h1 << s), "R3 level updated", v, 32'h1 << s);
      reg_rd(3'd5, v); check(v == 0, "R3 pending untouched", v, 0);
      @(negedge clk); irq_i[s] = 1'b0;
      idle(2);
    end

    // R9 R10 simultaneous burst under back-pressure
    d0 = 32'h1234_5667; d1 = 32'hABCD_EF1E;
    reg_wr(3'd0, d0); reg_wr(3'd1, d1);
    reg_wr(3'd2, 32'hFF); reg_wr(3'd3, 32'h0F);
    stall_mode = 1'b1;
    base = log_n;
    @(negedge clk); irq_i = 8'hB6;
    idle(40);
    stall_mode = 1'b0;
    check(log_n == base + 5, "R9 message count", AW'(log_n - base), 5);
    begin
      int k = 0;
      for (int b = 0; b < NS; b++) begin
        if (8'hB6 & (8'h1 << b)) begin
          dsel = (8'h0F & (8'h1 << b)) ? d1 : d0;
          check(log_addr[base + k] == (dsel & ~32'h1F), "R9/R10 ordered address", log_addr[base + k], dsel & ~32'h1F);
          check(log_data[base + k] == (dsel & 32'h1F), "R9/R10 ordered data", log_data[base + k], dsel & 32'h1F);
          k++;
        end
      end
    end
    reg_rd(3'd5, v); check(v == 32'hB6, "R8 burst pending", v, 32'hB6);

    // R1 write to level ignored
    reg_wr(3'd4, 32'h0);
    reg_rd(3'd4, v); check(v == 32'hB6, "R1 level write ignored", v, 32'hB6);
    @(negedge clk); irq_i = '0;
    idle(3);

    // R2 held input sends one message; re-rise sends another
    reg_wr(3'd3, 32'h0);
    base = log_n;
    @(negedge clk); irq_i[3] = 1'b1;
    idle(25);
    check(log_n == base + 1, "R2 held high", AW'(log_n - base), 1);
    @(negedge clk); irq_i[3] = 1'b0;
    idle(2);
    @(negedge clk); irq_i[3] = 1'b1;
    idle(6);
    check(log_n == base + 2, "R2 re-rise", AW'(log_n - base), 2);
    // R8 clear by write
    reg_wr(3'd5, 32'h0);
    reg_rd(3'd5, v); check(v == 0, "R8 cleared by write", v, 0);
    @(negedge clk); irq_i = '0;
    idle(3);

    // R7 status views
    reg_wr(3'd2, 32'h3A); reg_wr(3'd3, 32'h96);
    @(negedge clk); irq_i = 8'h5C;
    idle(6);
    reg_rd(3'd6, v); check(v == (32'h5C & 32'h3A & ~32'h96 & 32'hFF), "R7 view class0", v, 32'h5C & 32'h3A & ~32'h96 & 32'hFF);
    reg_rd(3'd7, v); check(v == (32'h5C & 32'h3A & 32'h96), "R7 view class1", v, 32'h5C & 32'h3A & 32'h96);
    @(negedge clk); irq_i = '0;
    idle(6);

    finish_run();
  end
endmodule